// File: doc/BRIEF.md
# Four-Channel Whole-Bank Copy Engine

This block copies complete memory banks from one memory to another on behalf of a processor. It holds four channels, each wired to a fixed pair of memories. Channel 0 copies ROM to RAM. Channel 1 copies ROM to VRAM. Channel 2 copies RAM to VRAM. Channel 3 copies VRAM to RAM. Software programs a destination bank, a source bank and a number of banks through a byte-wide register port. It then arms the channel by writing a start code into the channel's control byte.

A single engine serves one channel at a time. Each step reads one 32-byte block from the source memory and then writes the same block to the destination memory. Both memories use a request/ready handshake, and a transfer happens in a cycle where both are high. Channels that touch VRAM hold still while the VRAM lock input is high, and carry on once it drops.

Top module: `dma_bank_copier`

## Requirements
- R1: Out of reset every register byte reads 0. Channel n owns register offsets 4n to 4n+3, holding the control byte at +0, the destination bank at +1, the source bank at +2 and the remaining bank count at +3. Register reads are combinational from `reg_addr`.
- R2: The control byte reads 0 when a channel is idle, 2 when it is armed, and 1 while it runs. Writing 2 to the control byte of an idle channel arms it, and the byte reads 2 right after that write. Any other control value is ignored, and so is any write to a byte of a channel that is not idle.
- R3: Each step performs one source handshake for a 32-byte block, then one destination handshake that carries exactly that block. The step index on `src_step` and `dst_step` counts 0, 1, 2 and so on within a bank.
- R4: The memory select code is 0 for RAM, 1 for ROM and 2 for VRAM. The channel pairs are (source, destination): ch0 (ROM, RAM), ch1 (ROM, VRAM), ch2 (RAM, VRAM), ch3 (VRAM, RAM). Channel 0 moves 8 KB banks, which is 256 steps. The other channels move 4 KB banks, which is 128 steps.
- R5: After each completed bank, the channel's source and destination bank bytes each increase by one, wrapping from 255 to 0, and its count byte decreases by one.
- R6: After the last step of the last bank, the control byte reads 0.
- R7: A channel armed with a count of 0 returns to 0 without issuing any memory request.
- R8: While `vram_lock` is high, a running channel that touches VRAM raises neither request and loses no data. Channel 0 ignores the lock.
- R9: When the engine is free, it starts the lowest-numbered armed channel. A running channel is never pre-empted.
- R10: An armed channel reads 1 one cycle after the engine is free to take it.
- R11: A request that is not yet accepted keeps its bank, step, select and data stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register offset from the block's base |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| vram_lock | input | 1 | VRAM bus lock |
| src_req | output | 1 | Source block read request |
| src_sel | output | 2 | Source memory select |
| src_bank | output | 8 | Source bank number |
| src_step | output | 8 | 32-byte block index within the source bank |
| src_ready | input | 1 | Source accepts the request and presents data |
| src_data | input | 256 | Source block data |
| dst_req | output | 1 | Destination block write request |
| dst_sel | output | 2 | Destination memory select |
| dst_bank | output | 8 | Destination bank number |
| dst_step | output | 8 | 32-byte block index within the destination bank |
| dst_data | output | 256 | Destination block data |
| dst_ready | input | 1 | Destination accepts the write |

## Verification
Two events can land on the same clock edge: a channel's final destination handshake, which returns its control byte to 0, and a register write that arms a different channel. The bench watches the ports until the last step of a channel 3 transfer is visible, with its handshake about to complete. It then drives the start write for channel 0 on that same edge. The result is judged from the control bytes: channel 3 must read 0 and channel 0 must read 2 right after that edge, and channel 0 must read 1 one cycle later. Channel 0 must then copy its full bank with correct data.

// File: rtl/dma_copy_pkg.sv
`timescale 1ns/1ps
package dma_copy_pkg;
  localparam int CH_N = 4;
  localparam int CH_W = 2;

  typedef enum logic [1:0] {MEM_RAM = 2'd0, MEM_ROM = 2'd1, MEM_VRAM = 2'd2} mem_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_READ = 2'd1, ST_WRITE = 2'd2} eng_st_e;

  function automatic logic [1:0] src_mem(input logic [CH_W-1:0] ch);
    case (ch)
      2'd0, 2'd1: src_mem = MEM_ROM;
      2'd2:       src_mem = MEM_RAM;
      default:    src_mem = MEM_VRAM;
    endcase
  endfunction

  function automatic logic [1:0] dst_mem(input logic [CH_W-1:0] ch);
    case (ch)
      2'd1, 2'd2: dst_mem = MEM_VRAM;
      default:    dst_mem = MEM_RAM;
    endcase
  endfunction

  function automatic logic touches_vram(input logic [CH_W-1:0] ch);
    touches_vram = (src_mem(ch) == MEM_VRAM) || (dst_mem(ch) == MEM_VRAM);
  endfunction

  // index of the final step of a bank for this channel
  function automatic int unsigned last_step_of(input logic [CH_W-1:0] ch,
                                               input int unsigned small_steps,
                                               input int unsigned large_steps);
    last_step_of = (touches_vram(ch) ? small_steps : large_steps) - 1;
  endfunction
endpackage

// File: rtl/dma_copy_arb.sv
`timescale 1ns/1ps
module dma_copy_arb #(
  parameter int N = 4,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     pend,
  output logic             vld,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    vld = |pend;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/dma_copy_regs.sv
`timescale 1ns/1ps
module dma_copy_regs
  import dma_copy_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [3:0]                  addr,
  input  logic                        wr_en,
  input  logic [REG_W-1:0]            wr_data,
  output logic [REG_W-1:0]            rd_data,
  input  logic                        grant_vld,
  input  logic [CH_W-1:0]             grant_ch,
  input  logic                        bank_done,
  input  logic [CH_W-1:0]             done_ch,
  output logic [CH_N-1:0][1:0]        ctrl_o,
  output logic [CH_N-1:0][REG_W-1:0]  dbank_o,
  output logic [CH_N-1:0][REG_W-1:0]  sbank_o,
  output logic [CH_N-1:0][REG_W-1:0]  cnt_o
);
  localparam logic [1:0] C_IDLE = 2'd0, C_RUN = 2'd1, C_ARMED = 2'd2;

  logic [CH_N-1:0] run_v;

  for (genvar i = 0; i < CH_N; i++) begin : g_ch
    wire hit_w = wr_en && (addr[3:2] == CH_W'(i)) && (ctrl_o[i] == C_IDLE);
    assign run_v[i] = (ctrl_o[i] == C_RUN);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctrl_o[i]  <= C_IDLE;
        dbank_o[i] <= '0;
        sbank_o[i] <= '0;
        cnt_o[i]   <= '0;
      end else if (grant_vld && grant_ch == CH_W'(i)) begin
        ctrl_o[i] <= (cnt_o[i] == '0) ? C_IDLE : C_RUN;
      end else if (bank_done && done_ch == CH_W'(i)) begin
        dbank_o[i] <= dbank_o[i] + 1'b1;
        sbank_o[i] <= sbank_o[i] + 1'b1;
        cnt_o[i]   <= cnt_o[i] - 1'b1;
        if (cnt_o[i] == REG_W'(1)) ctrl_o[i] <= C_IDLE;
      end else if (hit_w) begin
        case (addr[1:0])
          2'd0: if (wr_data == REG_W'(C_ARMED)) ctrl_o[i] <= C_ARMED;
          2'd1: dbank_o[i] <= wr_data;
          2'd2: sbank_o[i] <= wr_data;
          default: cnt_o[i] <= wr_data;
        endcase
      end
    end

    // R6: a running channel never falls back to the armed code
    a_r6_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_o[i] == C_RUN) |=> (ctrl_o[i] != C_ARMED));
  end

  always_comb begin
    case (addr[1:0])
      2'd0:    rd_data = REG_W'(ctrl_o[addr[3:2]]);
      2'd1:    rd_data = dbank_o[addr[3:2]];
      2'd2:    rd_data = sbank_o[addr[3:2]];
      default: rd_data = cnt_o[addr[3:2]];
    endcase
  end

  // R9: at most one channel runs at a time
  a_r9_single_run: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(run_v));
endmodule

// File: rtl/dma_copy_engine.sv
`timescale 1ns/1ps
module dma_copy_engine
  import dma_copy_pkg::*;
#(
  parameter int STEP_BYTES = 32,
  parameter int SMALL_BANK = 4096,
  parameter int LARGE_BANK = 8192,
  parameter int REG_W      = 8,
  localparam int DATA_W      = STEP_BYTES * 8,
  localparam int SMALL_STEPS = SMALL_BANK / STEP_BYTES,
  localparam int LARGE_STEPS = LARGE_BANK / STEP_BYTES,
  localparam int STEP_W      = $clog2(LARGE_STEPS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        arb_vld,
  input  logic [CH_W-1:0]             arb_idx,
  input  logic [CH_N-1:0][REG_W-1:0]  dbank_i,
  input  logic [CH_N-1:0][REG_W-1:0]  sbank_i,
  input  logic [CH_N-1:0][REG_W-1:0]  cnt_i,
  input  logic                        vram_lock,
  output logic                        grant_vld,
  output logic                        bank_done,
  output logic [CH_W-1:0]             act_ch,
  output logic                        src_req,
  output logic [1:0]                  src_sel,
  output logic [REG_W-1:0]            src_bank,
  output logic [STEP_W-1:0]           src_step,
  input  logic                        src_ready,
  input  logic [DATA_W-1:0]           src_data,
  output logic                        dst_req,
  output logic [1:0]                  dst_sel,
  output logic [REG_W-1:0]            dst_bank,
  output logic [STEP_W-1:0]           dst_step,
  output logic [DATA_W-1:0]           dst_data,
  input  logic                        dst_ready
);
  eng_st_e           st_q;
  logic [STEP_W-1:0] step_q;
  logic [DATA_W-1:0] buf_q;
  logic              stall, src_fire, dst_fire, last_step;

  always_comb begin
    stall     = touches_vram(act_ch) && vram_lock;
    src_req   = (st_q == ST_READ) && !stall;
    dst_req   = (st_q == ST_WRITE) && !stall;
    src_fire  = src_req && src_ready;
    dst_fire  = dst_req && dst_ready;
    last_step = step_q == STEP_W'(last_step_of(act_ch, SMALL_STEPS, LARGE_STEPS));
    grant_vld = (st_q == ST_IDLE) && arb_vld;
    bank_done = dst_fire && last_step;
    src_sel   = src_mem(act_ch);
    dst_sel   = dst_mem(act_ch);
    src_bank  = sbank_i[act_ch];
    dst_bank  = dbank_i[act_ch];
    src_step  = step_q;
    dst_step  = step_q;
    dst_data  = buf_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      act_ch <= '0;
      step_q <= '0;
      buf_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (arb_vld) begin
          act_ch <= arb_idx;
          step_q <= '0;
          if (cnt_i[arb_idx] != '0) st_q <= ST_READ;
        end
        ST_READ: if (src_fire) begin
          buf_q <= src_data;
          st_q  <= ST_WRITE;
        end
        ST_WRITE: if (dst_fire) begin
          if (last_step) begin
            step_q <= '0;
            st_q   <= (cnt_i[act_ch] == REG_W'(1)) ? ST_IDLE : ST_READ;
          end else begin
            step_q <= step_q + 1'b1;
            st_q   <= ST_READ;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R8: no request toward either memory while VRAM is locked and involved
  a_r8_lock_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (vram_lock && (src_sel == MEM_VRAM || dst_sel == MEM_VRAM)) |-> (!src_req && !dst_req));
  // R11: an unaccepted read keeps its address fields
  a_r11_src_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req && !src_ready) |=> ($stable(src_bank) && $stable(src_step) && $stable(src_sel)));
  // R11: an unaccepted write keeps its data
  a_r11_dst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_req && !dst_ready) |=> ($stable(dst_data) && $stable(dst_step)));
  // R3: a write step index stays inside the bank
  a_r3_step_range: assert property (@(posedge clk) disable iff (!rst_n)
    dst_req |-> (int'(dst_step) < ((dst_sel == MEM_VRAM || src_sel == MEM_VRAM) ? SMALL_STEPS : LARGE_STEPS)));
endmodule

// File: rtl/dma_bank_copier.sv
`timescale 1ns/1ps
module dma_bank_copier
  import dma_copy_pkg::*;
#(
  parameter int STEP_BYTES = 32,
  parameter int SMALL_BANK = 4096,
  parameter int LARGE_BANK = 8192
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic [3:0]                                 reg_addr,
  input  logic                                       reg_we,
  input  logic [7:0]                                 reg_wdata,
  output logic [7:0]                                 reg_rdata,
  input  logic                                       vram_lock,
  output logic                                       src_req,
  output logic [1:0]                                 src_sel,
  output logic [7:0]                                 src_bank,
  output logic [$clog2(LARGE_BANK/STEP_BYTES)-1:0]   src_step,
  input  logic                                       src_ready,
  input  logic [STEP_BYTES*8-1:0]                    src_data,
  output logic                                       dst_req,
  output logic [1:0]                                 dst_sel,
  output logic [7:0]                                 dst_bank,
  output logic [$clog2(LARGE_BANK/STEP_BYTES)-1:0]   dst_step,
  output logic [STEP_BYTES*8-1:0]                    dst_data,
  input  logic                                       dst_ready
);
  localparam int REG_W = 8;

  logic [CH_N-1:0][1:0]       ctrl;
  logic [CH_N-1:0][REG_W-1:0] dbank, sbank, cnt;
  logic [CH_N-1:0]            pend;
  logic                       arb_vld, grant_vld, bank_done;
  logic [CH_W-1:0]            arb_idx, act_ch;

  for (genvar i = 0; i < CH_N; i++) begin : g_pend
    assign pend[i] = (ctrl[i] == 2'd2);
  end

  dma_copy_arb #(.N(CH_N)) u_arb (.pend(pend), .vld(arb_vld), .idx(arb_idx));

  dma_copy_regs #(.REG_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr_en(reg_we), .wr_data(reg_wdata),
    .rd_data(reg_rdata), .grant_vld(grant_vld), .grant_ch(arb_idx),
    .bank_done(bank_done), .done_ch(act_ch),
    .ctrl_o(ctrl), .dbank_o(dbank), .sbank_o(sbank), .cnt_o(cnt));

  dma_copy_engine #(.STEP_BYTES(STEP_BYTES), .SMALL_BANK(SMALL_BANK),
                    .LARGE_BANK(LARGE_BANK), .REG_W(REG_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .arb_vld(arb_vld), .arb_idx(arb_idx),
    .dbank_i(dbank), .sbank_i(sbank), .cnt_i(cnt), .vram_lock(vram_lock),
    .grant_vld(grant_vld), .bank_done(bank_done), .act_ch(act_ch),
    .src_req(src_req), .src_sel(src_sel), .src_bank(src_bank), .src_step(src_step),
    .src_ready(src_ready), .src_data(src_data),
    .dst_req(dst_req), .dst_sel(dst_sel), .dst_bank(dst_bank), .dst_step(dst_step),
    .dst_data(dst_data), .dst_ready(dst_ready));
endmodule

// File: tb/tb_dma_bank_copier.sv
`timescale 1ns/1ps
module tb_dma_bank_copier;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   reg_addr = '0;
  logic         reg_we = 1'b0;
  logic [7:0]   reg_wdata = '0;
  logic [7:0]   reg_rdata;
  logic         vram_lock = 1'b0;
  logic         src_req, dst_req;
  logic [1:0]   src_sel, dst_sel;
  logic [7:0]   src_bank, dst_bank, src_step, dst_step;
  logic [255:0] src_data, dst_data;
  logic         src_ready, dst_ready;
  logic         slow = 1'b0, tick = 1'b0;

  int total = 0, bad = 0;
  int beats [4];
  logic [7:0] m_s [4], m_d [4];
  int m_step [4];
  int mon_err = 0, locked_req = 0;
  logic [7:0] rv;

  always #4 clk = ~clk;

  dma_bank_copier dut (.*);

  function automatic logic [255:0] pat(input logic [1:0] sel, input logic [7:0] bank, input logic [7:0] step);
    return {8{~step, bank, 6'd0, sel, step}};
  endfunction
  // R4 channel pairs restated: (src,dst) codes RAM=0 ROM=1 VRAM=2
  function automatic logic [1:0] tsrc(input int ch);
    return (ch <= 1) ? 2'd1 : (ch == 2) ? 2'd0 : 2'd2;
  endfunction
  function automatic int infer(input logic [1:0] s, input logic [1:0] d);
    if (s == 2'd1 && d == 2'd0) return 0;
    if (s == 2'd1 && d == 2'd2) return 1;
    if (s == 2'd0 && d == 2'd2) return 2;
    if (s == 2'd2 && d == 2'd0) return 3;
    return 4;
  endfunction
  function automatic int steps(input int ch);
    return (ch == 0) ? 256 : 128;
  endfunction

  assign src_data  = pat(src_sel, src_bank, src_step);
  assign src_ready = slow ? tick : 1'b1;
  assign dst_ready = slow ? ~tick : 1'b1;

  always @(posedge clk) begin #2 tick = ~tick; end

  always @(negedge clk) begin
    if (rst_n && dst_req && dst_ready) begin
      automatic int ch = infer(src_sel, dst_sel);
      if (ch == 4) mon_err++;
      else begin
        if (dst_bank != m_d[ch] || int'(dst_step) != m_step[ch] ||
            dst_data != pat(tsrc(ch), m_s[ch], 8'(m_step[ch]))) mon_err++;
        beats[ch]++;
        m_step[ch]++;
        if (m_step[ch] == steps(ch)) begin
          m_step[ch] = 0; m_s[ch] = m_s[ch] + 8'd1; m_d[ch] = m_d[ch] + 8'd1;
        end
      end
    end
    if (rst_n && vram_lock && (src_req || dst_req) && infer(src_sel, dst_sel) != 0) locked_req++;
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int v);
    @(negedge clk);
    reg_addr = 4'(a); reg_wdata = 8'(v); reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic peek(input int a);
    reg_addr = 4'(a);
    #1 rv = reg_rdata;
  endtask

  task automatic prog(input int ch, input int d, input int s, input int c);
    wr(4*ch+1, d); wr(4*ch+2, s); wr(4*ch+3, c);
    m_d[ch] = 8'(d); m_s[ch] = 8'(s); m_step[ch] = 0; beats[ch] = 0;
  endtask

  task automatic wait_idle(input int ch, input string tag);
    automatic bit done = 1'b0;
    for (int w = 0; w < 40000 && !done; w++) begin
      @(negedge clk);
      peek(4*ch);
      if (rv == 8'd0) done = 1'b1;
    end
    check(tag, int'(done), 1);
  endtask

  localparam logic [26:0] VEC [6] = '{
    {2'd0, 8'h10, 8'h03, 8'd1, 1'b0},
    {2'd1, 8'h20, 8'hFF, 8'd2, 1'b0},
    {2'd2, 8'hFE, 8'h40, 8'd3, 1'b1},
    {2'd3, 8'h07, 8'h08, 8'd1, 1'b1},
    {2'd1, 8'h00, 8'h00, 8'd0, 1'b0},
    {2'd2, 8'h11, 8'h12, 8'd1, 1'b0}};

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin beats[i] = 0; m_step[i] = 0; m_s[i] = 0; m_d[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: all bytes zero after reset
    for (int a = 0; a < 16; a++) begin peek(a); check("R1 reset value", int'(rv), 0); end

    // table walk: R2 R3 R4 R5 R6 R7 R10
    for (int k = 0; k < 6; k++) begin
      automatic int ch = int'(VEC[k][26:25]);
      automatic int d  = int'(VEC[k][24:17]);
      automatic int s  = int'(VEC[k][16:9]);
      automatic int c  = int'(VEC[k][8:1]);
      slow = VEC[k][0];
      prog(ch, d, s, c);
      mon_err = 0;
      wr(4*ch, 2);
      peek(4*ch); check("R2 armed reads 2", int'(rv), 2);
      @(negedge clk);
      peek(4*ch); check(c == 0 ? "R7 zero count idle" : "R10 running reads 1", int'(rv), c == 0 ? 0 : 1);
      wait_idle(ch, "R6 control returns to 0");
      check("R4 beats per bank size", beats[ch], c * steps(ch));
      check("R3 block data and order", mon_err, 0);
      peek(4*ch+1); check("R5 destination bank advanced", int'(rv), (d + c) % 256);
      peek(4*ch+2); check("R5 source bank advanced", int'(rv), (s + c) % 256);
      peek(4*ch+3); check("R5 count reaches 0", int'(rv), 0);
    end
    slow = 1'b0;

    // R2 ignored writes, R9 priority
    prog(0, 1, 2, 1); prog(1, 3, 4, 1); prog(3, 5, 6, 1);
    mon_err = 0;
    wr(0, 2);
    wr(12, 2); wr(4, 2);
    wr(1, 8'h77); peek(1); check("R2 write to running bank ignored", int'(rv), 1);
    wr(0, 0); peek(0); check("R2 control write while running ignored", int'(rv), 1);
    wait_idle(0, "R6 ch0 done");
    @(negedge clk);
    peek(4);  check("R9 lower channel granted first", int'(rv), 1);
    peek(12); check("R9 higher channel still armed", int'(rv), 2);
    wait_idle(1, "R6 ch1 done");
    wait_idle(3, "R6 ch3 done");
    check("R9 ch1 beats", beats[1], 128);
    check("R9 ch3 beats", beats[3], 128);
    check("R3 priority run data", mon_err, 0);

    // R8 lock stalls a VRAM channel
    prog(1, 8'h08, 8'h09, 1);
    mon_err = 0; locked_req = 0;
    wr(4, 2);
    repeat (20) @(negedge clk);
    #1 vram_lock = 1'b1;
    begin
      automatic int b0 = beats[1];
      repeat (40) @(negedge clk);
      check("R8 no request while locked", locked_req, 0);
      check("R8 no progress while locked", beats[1], b0);
      peek(4); check("R8 still running", int'(rv), 1);
    end
    #1 vram_lock = 1'b0;
    wait_idle(1, "R8 resumes and ends");
    check("R8 full bank after lock", beats[1], 128);
    check("R8 data after lock", mon_err, 0);

    // R8 channel 0 ignores the lock
    @(negedge clk); #1 vram_lock = 1'b1;
    prog(0, 8'h60, 8'h61, 1);
    wr(0, 2);
    wait_idle(0, "R8 ch0 ends under lock");
    check("R8 ch0 beats under lock", beats[0], 256);
    @(negedge clk); #1 vram_lock = 1'b0;

    // same-edge: ch3 finishes while ch0 is armed
    prog(0, 8'h50, 8'h51, 1);
    prog(3, 8'h30, 8'h31, 1);
    mon_err = 0;
    wr(12, 2);
    begin
      automatic bit seen = 1'b0;
      for (int w = 0; w < 5000 && !seen; w++) begin
        @(negedge clk);
        if (dst_req && dst_ready && dst_step == 8'd127 && dst_sel == 2'd0) seen = 1'b1;
      end
      check("R6 ch3 last step reached", int'(seen), 1);
    end
    #1 reg_addr = 4'd0; reg_wdata = 8'd2; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    peek(12); check("R6 ch3 idle at shared edge", int'(rv), 0);
    peek(0);  check("R2 ch0 armed at shared edge", int'(rv), 2);
    @(negedge clk);
    peek(0);  check("R10 ch0 starts next cycle", int'(rv), 1);
    wait_idle(0, "R6 ch0 after shared edge");
    check("R4 ch0 bank after shared edge", beats[0], 256);
    check("R4 ch3 bank before shared edge", beats[3], 128);
    check("R3 shared edge data", mon_err, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule